// File: doc/BRIEF.md
# Supply Rail Self-Bias and Fault Supervisor

This block is the control state machine that sits behind the supply-rail comparators of an offline switching controller. It gates a high-voltage start-up current source that keeps the controller's supply capacitor between two levels. It also allows or blocks the switching stage, and it carries the controller through two fault modes. An overload is judged with the supply capacitor's own discharge as the timer: the flag is read when the rail has fallen from the upper level to the lower level. If the overload is still present, the block enters a low-power hiccup that restarts by itself. An overvoltage trip, or an external latch request on the same input, stops switching until the rail collapses below the power-on clear level.

All seven inputs are asynchronous comparator bits. Each passes through a synchronizer before use. Every output is registered. A one-cycle soft-start trigger marks each point where switching resumes after a ramp of the supply. Pulling the feedback below the skip level masks switching only while it lasts.

Top module: `supply_guard`

## Requirements
- R1: After reset, and whenever the rail is below the upper level in the start-up phase, `hv_src_en`=1, `sw_en`=0 and `standby`=0. Switching starts once `sup_above_hi`=1.
- R2: While running, the source turns on when `sup_below_lo`=1 and off when `sup_above_hi`=1. `sw_en` stays 1 in both phases, and a rail between the levels keeps the current phase.
- R3: In the discharge phase, if `overload`=1 at the moment `sup_below_lo` becomes 1, the block enters the overload latch: `sw_en`=0, `hv_src_en`=0, `standby`=1.
- R4: The overload latch holds, even after `overload` clears, until `sup_below_rst`=1. It then returns to start-up with `hv_src_en`=1, `standby`=0 and `sw_en`=0.
- R5: If `overload` has cleared before `sup_below_lo` rises, the block enters the normal charge phase and no fault cycle occurs.
- R6: `ovp_trip`=1, even as a single pulse, stops switching for good. In that latch the source turns on at `sup_below_rst`=1 and off at `sup_above_hi`=1. `standby` stays 0.
- R7: Only `sup_below_clr`=1 leaves the overvoltage latch, and it forces start-up from any state. The level that ends the overload latch does not clear it.
- R8: `ss_start` is a one-cycle pulse issued only on the move from start-up to switching. It fires once per ramp and never during normal hysteretic cycling.
- R9: `fb_shutdown`=1 forces `sw_en`=0 without changing state. When it returns to 0, switching resumes with no new `ss_start`.
- R10: Each input passes through SYNC_STAGES (default 2) flops. An input changed between edges reaches the outputs on the (SYNC_STAGES+1)-th rising edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_above_hi | input | 1 | Rail at or above the upper (about 12 V) level |
| sup_below_lo | input | 1 | Rail at or below the lower (about 10 V) level |
| sup_below_rst | input | 1 | Rail at or below the latch-end (about 5.3 V) level |
| sup_below_clr | input | 1 | Rail below the power-on clear (about 4 V) level |
| overload | input | 1 | Feedback pinned at its maximum |
| ovp_trip | input | 1 | Overvoltage or external latch request |
| fb_shutdown | input | 1 | Feedback pulled below the skip level |
| hv_src_en | output | 1 | Start-up current source enable |
| sw_en | output | 1 | Switching enable |
| standby | output | 1 | Low-power standby during overload latch |
| ss_start | output | 1 | One-cycle soft-start trigger |

## Verification
The bench walks the rail through hysteresis in both directions. It checks that a rail between the levels keeps the current phase, since a design that decoded levels alone would chatter the source. It clears the overload just before the lower level is reached and expects a normal charge. It removes the overload during the latch and expects the latch to hold until the latch-end level. Getting the sampling point wrong here would hiccup a healthy supply or release an overloaded one. The overvoltage trip is a single pulse, and the rail is then cycled through the latch-end level. A design that shared the overload exit would restart switching there. Counting soft-start triggers and checking the synchronizer latency edge by edge catches extra pulses and a missing or extra synchronizer stage.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [2:0] {
    ST_STARTUP       = 3'd0,
    ST_RUN_CHARGE    = 3'd1,
    ST_RUN_DISCHARGE = 3'd2,
    ST_OVL_LATCH     = 3'd3,
    ST_OVP_LATCH     = 3'd4
  } sg_state_e;

  typedef struct packed {
    logic src;
    logic sw;
    logic stby;
  } sg_out_t;

  localparam int unsigned SG_NUM_IN = 7;
endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/sg_decode.sv
module sg_decode
  import sg_pkg::*;
(
  input  sg_state_e st,
  input  logic      ovp_charge,
  output sg_out_t   o
);
  always_comb begin
    o = '0;
    unique case (st)
      ST_STARTUP:       o.src = 1'b1;
      ST_RUN_CHARGE:    begin o.src = 1'b1; o.sw = 1'b1; end
      ST_RUN_DISCHARGE: o.sw = 1'b1;
      ST_OVL_LATCH:     o.stby = 1'b1;
      ST_OVP_LATCH:     o.src = ovp_charge;
      default:          o = '0;
    endcase
  end
endmodule

// File: rtl/sg_fsm.sv
module sg_fsm
  import sg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic above_hi,
  input  logic below_lo,
  input  logic below_rst,
  input  logic below_clr,
  input  logic ovl,
  input  logic ovp,
  input  logic fb_off,
  output logic src_q,
  output logic sw_q,
  output logic stby_q,
  output logic ss_q
);
  sg_state_e state_q, state_d;
  logic      chg_q, chg_d;
  sg_out_t   dec;

  always_comb begin
    state_d = state_q;
    chg_d   = chg_q;
    if (below_clr) begin
      state_d = ST_STARTUP;
      chg_d   = 1'b0;
    end else if (ovp && state_q != ST_OVP_LATCH) begin
      state_d = ST_OVP_LATCH;
      chg_d   = (state_q == ST_STARTUP || state_q == ST_RUN_CHARGE) && !above_hi;
    end else begin
      unique case (state_q)
        ST_STARTUP:       if (above_hi) state_d = ST_RUN_DISCHARGE;
        ST_RUN_DISCHARGE: if (below_lo) state_d = ovl ? ST_OVL_LATCH : ST_RUN_CHARGE;
        ST_RUN_CHARGE:    if (above_hi) state_d = ST_RUN_DISCHARGE;
        ST_OVL_LATCH:     if (below_rst) state_d = ST_STARTUP;
        ST_OVP_LATCH: begin
          if (below_rst)     chg_d = 1'b1;
          else if (above_hi) chg_d = 1'b0;
        end
        default:          state_d = ST_STARTUP;
      endcase
    end
  end

  sg_decode u_dec (
    .st         (state_d),
    .ovp_charge (chg_d),
    .o          (dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_STARTUP;
      chg_q   <= 1'b0;
      src_q   <= 1'b1;
      sw_q    <= 1'b0;
      stby_q  <= 1'b0;
      ss_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      chg_q   <= chg_d;
      src_q   <= dec.src;
      sw_q    <= dec.sw && !fb_off;
      stby_q  <= dec.stby;
      ss_q    <= (state_q == ST_STARTUP) && (state_d == ST_RUN_DISCHARGE);
    end
  end
endmodule

// File: rtl/supply_guard.sv
module supply_guard #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sup_above_hi,
  input  logic sup_below_lo,
  input  logic sup_below_rst,
  input  logic sup_below_clr,
  input  logic overload,
  input  logic ovp_trip,
  input  logic fb_shutdown,
  output logic hv_src_en,
  output logic sw_en,
  output logic standby,
  output logic ss_start
);
  localparam int unsigned NIN = sg_pkg::SG_NUM_IN;

  logic [NIN-1:0] raw, syn;

  assign raw = {fb_shutdown, ovp_trip, overload, sup_below_clr,
                sup_below_rst, sup_below_lo, sup_above_hi};

  sg_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (raw),
    .d_out (syn)
  );

  sg_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .above_hi  (syn[0]),
    .below_lo  (syn[1]),
    .below_rst (syn[2]),
    .below_clr (syn[3]),
    .ovl       (syn[4]),
    .ovp       (syn[5]),
    .fb_off    (syn[6]),
    .src_q     (hv_src_en),
    .sw_q      (sw_en),
    .stby_q    (standby),
    .ss_q      (ss_start)
  );
endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk (
  input logic clk,
  input logic rst,
  input logic fb_shutdown,
  input logic hv_src_en,
  input logic sw_en,
  input logic standby,
  input logic ss_start
);
  logic fb_d1, fb_d2, fb_d3;

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_d1 <= 1'b0;
      fb_d2 <= 1'b0;
      fb_d3 <= 1'b0;
    end else begin
      fb_d1 <= fb_shutdown;
      fb_d2 <= fb_d1;
      fb_d3 <= fb_d2;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hv_src_en && !sw_en && !standby)); // R1
  AST_OVL_QUIET: assert property (@(posedge clk) disable iff (rst)
    standby |-> (!hv_src_en && !sw_en)); // R3
  AST_OVL_EXIT: assert property (@(posedge clk) disable iff (rst)
    $fell(standby) |-> (hv_src_en && !sw_en)); // R4
  AST_SS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ss_start |=> !ss_start); // R8
  AST_SS_CONTEXT: assert property (@(posedge clk) disable iff (rst)
    ss_start |-> (!hv_src_en && !standby)); // R8
  AST_FB_MASK: assert property (@(posedge clk) disable iff (rst)
    fb_d3 |-> !sw_en); // R9
endmodule

bind supply_guard supply_guard_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .fb_shutdown (fb_shutdown),
  .hv_src_en   (hv_src_en),
  .sw_en       (sw_en),
  .standby     (standby),
  .ss_start    (ss_start)
);

// File: tb/sim_supply_guard.sv
`timescale 1ns/1ps
module sim_supply_guard;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hi = 0, lo = 1, r53 = 1, c4 = 1, ovl = 0, ovp = 0, fbo = 0;
  logic src, sw, stby, ss;

  always #10 clk = ~clk;

  supply_guard u0 (
    .clk(clk), .rst(rst),
    .sup_above_hi(hi), .sup_below_lo(lo), .sup_below_rst(r53), .sup_below_clr(c4),
    .overload(ovl), .ovp_trip(ovp), .fb_shutdown(fbo),
    .hv_src_en(src), .sw_en(sw), .standby(stby), .ss_start(ss)
  );

  typedef struct {
    logic  src;
    logic  sw;
    logic  stby;
    int    ssn;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int checks = 0, failures = 0, ss_count = 0;
  bit done = 0;

  always @(negedge clk) if (!rst && ss) ss_count++;

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (src !== e.src || sw !== e.sw || stby !== e.stby || ss_count != e.ssn) begin
          failures++;
          $display("FAIL %s: got src=%0b sw=%0b stby=%0b ss=%0d exp src=%0b sw=%0b stby=%0b ss=%0d",
                   e.tag, src, sw, stby, ss_count, e.src, e.sw, e.stby, e.ssn);
        end
      end
    end
  end

  // levels: 0 <4V, 1 <=5.3V, 2 <=10V, 3 between, 4 >=12V
  task automatic set_lvl(input int l);
    hi  = (l == 4);
    lo  = (l <= 2);
    r53 = (l <= 1);
    c4  = (l == 0);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_now(input logic s, input logic w, input logic b, input int n, input string t);
    exp_t e;
    e.src = s; e.sw = w; e.stby = b; e.ssn = n; e.tag = t;
    sbq.push_back(e);
  endtask

  task automatic step(input int l, input logic s, input logic w, input logic b, input int n, input string t);
    @(negedge clk);
    set_lvl(l);
    settle();
    expect_now(s, w, b, n, t);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_now(1, 0, 0, 0, "R1 reset state");
    step(3, 1, 0, 0, 0, "R1 startup below upper");
    // R10 latency: change at negedge, response on third rising edge
    @(negedge clk);
    set_lvl(4);
    repeat (2) @(negedge clk);
    expect_now(1, 0, 0, 0, "R10 no change after two edges");
    @(negedge clk);
    expect_now(0, 1, 0, 1, "R10 R8 response on third edge with soft-start");
    step(3, 0, 1, 0, 1, "R2 discharge holds between levels");
    step(2, 1, 1, 0, 1, "R2 source on at lower level");
    step(3, 1, 1, 0, 1, "R2 charge holds between levels");
    step(4, 0, 1, 0, 1, "R2 R8 source off at upper, no soft-start");
    @(negedge clk); fbo = 1; settle();
    expect_now(0, 0, 0, 1, "R9 feedback shutdown masks switching");
    @(negedge clk); fbo = 0; settle();
    expect_now(0, 1, 0, 1, "R9 shutdown released without soft-start");
    @(negedge clk); ovl = 1;
    step(3, 0, 1, 0, 1, "R3 overload monitored while falling");
    @(negedge clk); ovl = 0;
    step(2, 1, 1, 0, 1, "R5 overload cleared before lower level");
    step(4, 0, 1, 0, 1, "R2 back to discharge");
    @(negedge clk); ovl = 1;
    step(3, 0, 1, 0, 1, "R3 overload during discharge");
    step(2, 0, 0, 1, 1, "R3 overload latch at lower level");
    @(negedge clk); ovl = 0;
    step(3, 0, 0, 1, 1, "R4 latch holds after overload clears");
    step(2, 0, 0, 1, 1, "R4 latch holds above latch-end level");
    step(1, 1, 0, 0, 1, "R4 latch-end returns to startup");
    step(3, 1, 0, 0, 1, "R1 startup charging again");
    step(4, 0, 1, 0, 2, "R8 soft-start after hiccup");
    @(negedge clk); ovp = 1; @(negedge clk); ovp = 0; settle();
    expect_now(0, 0, 0, 2, "R6 ovp pulse stops switching");
    step(2, 0, 0, 0, 2, "R6 ovp source off while falling");
    step(1, 1, 0, 0, 2, "R6 R7 ovp source on at latch-end, still latched");
    step(3, 1, 0, 0, 2, "R6 ovp charging between levels");
    step(4, 0, 0, 0, 2, "R7 ovp no restart at upper level");
    step(1, 1, 0, 0, 2, "R6 ovp recharge");
    step(0, 1, 0, 0, 2, "R7 clear level forces startup");
    step(3, 1, 0, 0, 2, "R7 startup after clear");
    step(4, 0, 1, 0, 3, "R7 R8 switching resumes with soft-start");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule